// File: doc/BRIEF.md
# Iterative Signed Multiplier, Four Bits per Cycle

This block is the sequential multiplier of a 32-bit processor's multiply unit. The unit upstream extends both operands to 33 bits with a sign bit that it picks itself. As a result, signed-by-signed, signed-by-unsigned and unsigned-by-unsigned products all use one signed datapath. The block forms the full 64-bit product. It consumes one 4-bit digit of the multiplier per clock. Each digit's partial product is added into a right-shifting accumulator. After the last digit, the block presents the upper and lower 32-bit halves on separate outputs.

A command is started by holding `in_valid` high while the unit is idle. The block raises `out_ready` when the product is complete. It then keeps the result and `out_ready` unchanged until the consumer pulses `proc_done`. The consumer does this one cycle after it samples the ready flag. The pulse returns the unit to idle, so a `in_valid` that is still high while the unit holds its result does not start a second operation. Choosing a half, decoding the command and extending the operands are done outside the block.

Top module: `iter_mul4`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and after it is released, `out_ready` is 0 and both `prod_hi` and `prod_lo` are 0 until an operation completes.
- R2: When the block is idle and samples `in_valid` high on a rising edge, `out_ready` becomes 1 exactly W/DIG rising edges later (8 for W=32, DIG=4), and never rises without such a start.
- R3: The completed result `{prod_hi, prod_lo}` equals the low 2W bits of the two's-complement product of `op_a` and `op_b`, both read as signed (W+1)-bit values.
- R4: `prod_hi` carries product bits [2W-1:W] and `prod_lo` carries product bits [W-1:0].
- R5: While `out_ready` is 1 and `proc_done` is 0, `out_ready`, `prod_hi` and `prod_lo` keep their values, whatever `in_valid`, `op_a` and `op_b` do.
- R6: A `proc_done` sampled high while `out_ready` is 1 makes `out_ready` 0 on the next edge, and the unit is then idle and ready for a new start.
- R7: `proc_done` has no effect while the unit is idle or iterating: it neither produces `out_ready` nor changes the latency or the result.
- R8: The operands are captured on the start edge; changes to `op_a` and `op_b` during the iterations do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command pending; starts an operation when idle |
| op_a | input | W+1 | Multiplicand, signed, already extended |
| op_b | input | W+1 | Multiplier, signed, already extended |
| prod_hi | output | W | Upper half of the product |
| prod_lo | output | W | Lower half of the product |
| out_ready | output | 1 | Product complete and held |
| proc_done | input | 1 | Consumer acknowledge; releases the unit |

## Verification
At W=8, a reduced instance runs a full sweep of every 9-bit multiplicand against 32 multipliers. These include the most negative value, minus one and the largest positive value. The sweep shows whether the negative weighting of the final digit and the carry between digits are right. At W=32, directed cases check the product and the latency. They use most-negative squared, minus one times a positive value, zero on either side, the unsigned maximum squared, and mixed-sign operand pairs, which separate signed and unsigned extension behaviour. Separate sequences toggle the operands and `proc_done` during iteration, and hold `in_valid` high after completion. These show that capture, holding and release are separate from the arithmetic.

// File: rtl/iter_mul4.sv
module iter_mul4 #(
  parameter int W   = 32,
  parameter int DIG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W:0]   op_a,
  input  logic signed [W:0]   op_b,
  output logic [W-1:0]        prod_hi,
  output logic [W-1:0]        prod_lo,
  output logic                out_ready,
  input  logic                proc_done
);

  localparam int ITER = W / DIG;
  localparam int CW   = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int AW   = W + DIG + 3;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} state_t;

  state_t              state;
  logic [CW-1:0]       cnt;
  logic signed [W:0]   mcand;
  logic signed [W:0]   mplier;
  logic signed [AW-1:0] acc;
  logic [W-1:0]        lo;

  logic                last;
  logic signed [DIG:0] digit;
  logic signed [AW-1:0] pp;
  logic signed [AW-1:0] sum;

  // final digit carries the sign bit and is weighted negatively
  assign last  = (cnt == CW'(ITER - 1));
  assign digit = last ? mplier[DIG:0] : {1'b0, mplier[DIG-1:0]};
  assign pp    = $signed({{(AW-W-1){mcand[W]}}, mcand})
               * $signed({{(AW-DIG-1){digit[DIG]}}, digit});
  assign sum   = acc + pp;

  assign prod_hi = acc[W-1:0];
  assign prod_lo = lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mcand     <= '0;
      mplier    <= '0;
      acc       <= '0;
      lo        <= '0;
      out_ready <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            mcand  <= op_a;
            mplier <= op_b;
            acc    <= '0;
            lo     <= '0;
            cnt    <= '0;
            state  <= S_RUN;
          end
        end
        S_RUN: begin
          acc    <= sum >>> DIG;
          lo     <= {sum[DIG-1:0], lo[W-1:DIG]};
          mplier <= mplier >>> DIG;
          cnt    <= cnt + 1'b1;
          if (last) begin
            state     <= S_HOLD;
            out_ready <= 1'b1;
          end
        end
        S_HOLD: begin
          if (proc_done) begin
            state     <= S_IDLE;
            out_ready <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iter_mul4_chk.sv
module iter_mul4_chk #(
  parameter int W   = 32,
  parameter int DIG = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo,
  input logic         out_ready,
  input logic         proc_done
);

  localparam int ITER = W / DIG;

  logic        busy_c;
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c  <= 1'b0;
      lat_cnt <= '0;
    end else if (!busy_c && !out_ready && in_valid) begin
      busy_c  <= 1'b1;
      lat_cnt <= '0;
    end else if (busy_c && out_ready) begin
      busy_c  <= 1'b0;
    end else if (busy_c) begin
      lat_cnt <= lat_cnt + 16'd1;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> (busy_c && lat_cnt == 16'(ITER))); // R2

  AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_c && !out_ready && !in_valid) |=> !out_ready); // R2

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !proc_done) |=> out_ready); // R5

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !proc_done) |=> ($stable(prod_hi) && $stable(prod_lo))); // R5

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && proc_done) |=> !out_ready); // R6

endmodule

bind iter_mul4 iter_mul4_chk #(.W(W), .DIG(DIG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .prod_hi   (prod_hi),
  .prod_lo   (prod_lo),
  .out_ready (out_ready),
  .proc_done (proc_done)
);

// File: tb/tb_iter_mul4.sv
module tb_iter_mul4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // full-size instance
  logic        valid = 1'b0, done = 1'b0, ready;
  logic [32:0] a = '0, b = '0;
  logic [31:0] hi, lo;

  iter_mul4 #(.W(32), .DIG(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(valid), .op_a(a), .op_b(b),
    .prod_hi(hi), .prod_lo(lo), .out_ready(ready), .proc_done(done));

  // reduced instance for the sweep
  logic       svalid = 1'b0, sdone = 1'b0, sready;
  logic [8:0] sa = '0, sb = '0;
  logic [7:0] shi, slo;

  iter_mul4 #(.W(8), .DIG(4)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(svalid), .op_a(sa), .op_b(sb),
    .prod_hi(shi), .prod_lo(slo), .out_ready(sready), .proc_done(sdone));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [32:0] x, input logic [32:0] y);
    logic signed [65:0] xe, ye, p;
    xe = {{33{x[32]}}, x};
    ye = {{33{y[32]}}, y};
    p  = xe * ye;
    return p[63:0];
  endfunction

  // one full-size operation; optional disturbances during iteration
  task automatic big_op(input logic [32:0] x, input logic [32:0] y,
                        input bit disturb, input string tag);
    int lat;
    logic [63:0] exp;
    exp = ref_mul(x, y);
    @(negedge clk);
    a = x; b = y; valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (disturb) begin
        a = ~x; b = x ^ y;                // R8: operands change mid-run
        done = (lat == 3 || lat == 5);    // R7: acknowledge while iterating
      end
    end while (!ready && lat < 40);
    done = 1'b0;
    chk(lat == 9, {"R2 latency ", tag}, 64'(lat), 64'd9);
    chk({hi, lo} == exp, {"R3 product ", tag}, {hi, lo}, exp);
    chk(hi == exp[63:32], {"R4 upper half ", tag}, 64'(hi), 64'(exp[63:32]));
    valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(ready == 1'b0, {"R6 release ", tag}, 64'(ready), 64'd0);
  endtask

  initial begin
    logic [63:0] held;
    int sl;
    logic signed [17:0] sp;

    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready in reset", 64'(ready), 64'd0);
    chk({hi, lo} == 64'd0, "R1 product in reset", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b0 && {hi, lo} == 64'd0, "R1 after release", {63'd0, ready}, 64'd0);

    // R7: acknowledge while idle produces nothing
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R7 idle acknowledge", 64'(ready), 64'd0);

    big_op(33'h1_8000_0000, 33'h1_8000_0000, 1'b0, "minneg*minneg");
    big_op(33'h1_FFFF_FFFF, 33'h0_0000_1234, 1'b0, "-1*pos");
    big_op(33'h0_0000_1234, 33'h1_FFFF_FFFF, 1'b0, "pos*-1");
    big_op(33'h0_0000_0000, 33'h1_8765_4321, 1'b0, "0*x");
    big_op(33'h1_8765_4321, 33'h0_0000_0000, 1'b0, "x*0");
    big_op(33'h0_FFFF_FFFF, 33'h0_FFFF_FFFF, 1'b0, "umax*umax");
    big_op(33'h1_FFFF_FFFF, 33'h0_FFFF_FFFF, 1'b0, "-1*umax");
    big_op(33'h0_7FFF_FFFF, 33'h1_8000_0000, 1'b0, "maxpos*minneg");
    big_op(33'h0_00BC_614E, 33'h1_FAC6_804F, 1'b0, "mixed sign");
    big_op(33'h1_DEAD_BEEF, 33'h0_CAFE_F00D, 1'b1, "disturbed R7 R8");

    // R5: valid held high, no acknowledge, operands change
    @(negedge clk);
    a = 33'h0_1357_9BDF; b = 33'h1_2468_ACE0; valid = 1'b1;
    while (!ready) @(negedge clk);
    held = {hi, lo};
    chk(held == ref_mul(33'h0_1357_9BDF, 33'h1_2468_ACE0), "R3 hold case product",
        held, ref_mul(33'h0_1357_9BDF, 33'h1_2468_ACE0));
    for (int k = 0; k < 4; k++) begin
      a = 33'(k * 977); b = ~a;
      @(negedge clk);
      chk(ready == 1'b1 && {hi, lo} == held, "R5 held result", {hi, lo}, held);
    end
    valid = 1'b0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(ready == 1'b0, "R6 release after hold", 64'(ready), 64'd0);

    // reduced-size sweep: every multiplicand against 32 multipliers
    for (int ai = 0; ai < 512; ai++) begin
      for (int bi = 0; bi < 32; bi++) begin
        sa = 9'(ai);
        case (bi)
          0: sb = 9'h100;
          1: sb = 9'h1FF;
          2: sb = 9'h0FF;
          3: sb = 9'h000;
          default: sb = 9'((bi * 16 + ai * 3) & 511);
        endcase
        sp = $signed(sa) * $signed(sb);
        svalid = 1'b1;
        sl = 0;
        do begin
          @(negedge clk);
          sl++;
        end while (!sready && sl < 20);
        chk(sl == 3 && {shi, slo} == sp[15:0], "R3 R4 sweep W=8",
            {40'd0, 8'(sl), shi, slo}, {40'd0, 8'd3, sp[15:0]});
        svalid = 1'b0;
        sdone = 1'b1;
        @(negedge clk);
        sdone = 1'b0;
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule